// File: doc/BRIEF.md
# Data Separator Read-Mode Sequencer

This controller sits beside a data-separator phase-locked loop and decides, once per clock, which reference the loop tracks, which gain it runs at, and which phase comparator it uses. It also decides when the recovered read data and the NRZ data may leave the block. A bit-cell strobe paces it, together with a per-cell flag that reports whether the incoming cell matched the preamble frequency. The analog loop, the oscillator and address-mark matching sit outside.

Two lock algorithms are provided. The simple one locks to data as soon as the first raw pulse arrives after the read gate opens. The preamble-qualified one counts consecutive preamble cells. After 8 such cells it moves the loop onto the data in high gain. After 16 it enables the outputs. The first cell that breaks the preamble after that point drops the loop to low gain. Until the outputs are enabled, the qualified algorithm replaces the read data with a fixed byte pattern that repeats. The algorithm is latched when the read gate opens.

Top module: `rdsep_mode_seq`

## Requirements
- R1: While rd_gate_i is low, one clock after it was sampled low the outputs show reference lock (lock_data_o=0), high gain (high_gain_o=1) and the phase/frequency comparator (pf_comp_o=1). rdo_en_o, nrz_en_o, fill_active_o and out_oe_o are all 0.
- R2: four_state_i is sampled only on the clock where the sequencer leaves the gate-closed state. Changes to four_state_i during a read have no effect on the outputs.
- R3: In two-state mode (four_state_i=0 at gate rise), the loop stays on the reference until data_pulse_i is seen. On the next clock it switches to data lock, low gain, phase-only, with rdo_en_o=1, and holds there until the gate falls.
- R4: In two-state mode, nrz_en_o rises after the 8th cell_stb_i that follows the switch to data lock.
- R5: In four-state mode, the 8th consecutive cell strobe with pre_seen_i=1 moves the loop to data lock in high gain with the phase-only comparator (lock_data_o=1, high_gain_o=1, pf_comp_o=0).
- R6: In four-state mode, the 16th consecutive preamble cell sets rdo_en_o=1 and nrz_en_o=1 while the loop stays in high gain.
- R7: In four-state mode, a cell strobe with pre_seen_i=0 before the 16th preamble cell returns the loop to the reference (lock_data_o=0, pf_comp_o=1) and restarts the count from zero.
- R8: After the outputs are enabled in four-state mode, the first cell strobe with pre_seen_i=0 sets high_gain_o=0. Low gain then holds regardless of pre_seen_i until the gate falls.
- R9: In four-state mode, fill_active_o=1 from gate rise until the outputs are enabled, with nrz_en_o=0. fill_bit_o carries 8'h4E for MFM (mfm_i=1) or 8'hFF for FM (mfm_i=0), most significant bit first. It advances one bit per cell strobe and wraps after 8 bits.
- R10: out_oe_o is 1 only while a read is in progress, and it falls one clock after rd_gate_i is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_gate_i | input | 1 | Read gate from the controller |
| four_state_i | input | 1 | 1 = preamble-qualified algorithm, 0 = first-pulse algorithm |
| mfm_i | input | 1 | 1 = MFM, 0 = FM |
| cell_stb_i | input | 1 | One-clock strobe per bit cell |
| data_pulse_i | input | 1 | Raw data pulse seen this clock |
| pre_seen_i | input | 1 | Cell matched preamble frequency (valid with cell_stb_i) |
| high_gain_o | output | 1 | 1 = high loop gain |
| lock_data_o | output | 1 | 1 = loop tracks data, 0 = reference |
| pf_comp_o | output | 1 | 1 = phase/frequency comparator, 0 = phase-only |
| rdo_en_o | output | 1 | Enable for recovered read data |
| nrz_en_o | output | 1 | Enable for NRZ data |
| fill_active_o | output | 1 | Fill pattern replaces read data |
| fill_bit_o | output | 1 | Current fill pattern bit |
| out_oe_o | output | 1 | Output enable for NRZ and mark-found drivers |

## Verification
A wrong state in the sequencer shows up on the loop controls one clock after the strobe or pulse that caused it. A stray return to the reference, for example, raises pf_comp_o and drops lock_data_o at once. A count that is off by one moves the 8- or 16-cell thresholds by a cell, so the bench checks the outputs after every preamble strobe, right at each threshold. A fill index error shows within a single cell as a wrong fill_bit_o against the known byte.

// File: rtl/rdsep_pkg.sv
package rdsep_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,  // gate closed
    ST_REF  = 3'd1,  // gate open, on reference
    ST_HIGH = 3'd2,  // data lock, high gain, outputs held
    ST_OPEN = 3'd3,  // data lock, high gain, outputs enabled
    ST_LOW  = 3'd4   // data lock, low gain
  } seq_st_e;
endpackage

// File: rtl/rdsep_pre_cnt.sv
module rdsep_pre_cnt #(
  parameter int MAX = 16,
  localparam int W = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] TOP = W'(MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_o <= '0;
    else if (clr_i)              cnt_o <= '0;
    else if (inc_i && cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
  end

  p_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= TOP);
  p_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/rdsep_fill_gen.sv
module rdsep_fill_gen #(
  parameter int          FILL_W  = 8,
  parameter logic [FILL_W-1:0] MFM_PAT = 8'h4E,
  parameter logic [FILL_W-1:0] FM_PAT  = 8'hFF,
  localparam int IW = $clog2(FILL_W)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic step_i,
  input  logic mfm_i,
  output logic bit_o
);
  localparam logic [IW-1:0] LAST = IW'(FILL_W - 1);
  logic [IW-1:0]     idx_q;
  logic [FILL_W-1:0] pat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (!active_i) idx_q <= '0;
    else if (step_i)   idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  assign pat   = mfm_i ? MFM_PAT : FM_PAT;
  assign bit_o = pat[LAST - idx_q];

  p_fill_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !step_i) |=> $stable(idx_q) || !$past(active_i));
endmodule

// File: rtl/rdsep_out_dec.sv
module rdsep_out_dec
  import rdsep_pkg::*;
(
  input  seq_st_e st_i,
  input  logic    four_i,
  input  logic    nrz_ready_i,
  output logic    high_gain_o,
  output logic    lock_data_o,
  output logic    pf_comp_o,
  output logic    rdo_en_o,
  output logic    nrz_en_o,
  output logic    fill_active_o,
  output logic    oe_o
);
  always_comb begin
    high_gain_o   = 1'b1;
    lock_data_o   = 1'b0;
    pf_comp_o     = 1'b1;
    rdo_en_o      = 1'b0;
    nrz_en_o      = 1'b0;
    fill_active_o = 1'b0;
    oe_o          = 1'b1;
    unique case (st_i)
      ST_OFF:  oe_o = 1'b0;
      ST_REF:  fill_active_o = four_i;
      ST_HIGH: begin
        lock_data_o   = 1'b1;
        pf_comp_o     = 1'b0;
        fill_active_o = 1'b1;
      end
      ST_OPEN: begin
        lock_data_o = 1'b1;
        pf_comp_o   = 1'b0;
        rdo_en_o    = 1'b1;
        nrz_en_o    = 1'b1;
      end
      ST_LOW: begin
        high_gain_o = 1'b0;
        lock_data_o = 1'b1;
        pf_comp_o   = 1'b0;
        rdo_en_o    = 1'b1;
        nrz_en_o    = four_i | nrz_ready_i;
      end
      default: oe_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rdsep_mode_seq.sv
module rdsep_mode_seq
  import rdsep_pkg::*;
#(
  parameter int LOCK_CELLS = 8,
  parameter int OPEN_CELLS = 16,
  parameter int NRZ_DELAY  = 8,
  parameter int FILL_W     = 8,
  parameter logic [FILL_W-1:0] MFM_PAT = 8'h4E,
  parameter logic [FILL_W-1:0] FM_PAT  = 8'hFF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_gate_i,
  input  logic four_state_i,
  input  logic mfm_i,
  input  logic cell_stb_i,
  input  logic data_pulse_i,
  input  logic pre_seen_i,
  output logic high_gain_o,
  output logic lock_data_o,
  output logic pf_comp_o,
  output logic rdo_en_o,
  output logic nrz_en_o,
  output logic fill_active_o,
  output logic fill_bit_o,
  output logic out_oe_o
);
  localparam int CNT_MAX = (OPEN_CELLS > NRZ_DELAY) ? OPEN_CELLS : NRZ_DELAY;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LOCK_M1 = CNT_W'(LOCK_CELLS - 1);
  localparam logic [CNT_W-1:0] OPEN_M1 = CNT_W'(OPEN_CELLS - 1);
  localparam logic [CNT_W-1:0] NRZ_N   = CNT_W'(NRZ_DELAY);

  seq_st_e          st_q, st_d;
  logic             mode_q;
  logic [CNT_W-1:0] cnt;
  logic             cnt_clr, cnt_inc, pre_cell, miss_cell;

  assign pre_cell  = cell_stb_i & pre_seen_i;
  assign miss_cell = cell_stb_i & ~pre_seen_i;

  always_comb begin
    st_d = st_q;
    if (!rd_gate_i) st_d = ST_OFF;
    else begin
      unique case (st_q)
        ST_OFF: st_d = ST_REF;
        ST_REF: begin
          if (!mode_q) begin
            if (data_pulse_i) st_d = ST_LOW;
          end else if (pre_cell && cnt == LOCK_M1) st_d = ST_HIGH;
        end
        ST_HIGH: begin
          if (miss_cell) st_d = ST_REF;
          else if (pre_cell && cnt == OPEN_M1) st_d = ST_OPEN;
        end
        ST_OPEN: if (miss_cell) st_d = ST_LOW;
        ST_LOW:  st_d = ST_LOW;
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_OFF;
      mode_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_OFF && rd_gate_i) mode_q <= four_state_i;
    end
  end

  // four-state: run of preamble cells; two-state: cells since data lock
  always_comb begin
    if (mode_q) begin
      cnt_clr = ~rd_gate_i | miss_cell;
      cnt_inc = pre_cell;
    end else begin
      cnt_clr = ~rd_gate_i | (st_q != ST_LOW);
      cnt_inc = cell_stb_i;
    end
  end

  rdsep_pre_cnt #(.MAX(CNT_MAX)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .cnt_o  (cnt)
  );

  rdsep_out_dec u_dec (
    .st_i          (st_q),
    .four_i        (mode_q),
    .nrz_ready_i   (cnt >= NRZ_N),
    .high_gain_o   (high_gain_o),
    .lock_data_o   (lock_data_o),
    .pf_comp_o     (pf_comp_o),
    .rdo_en_o      (rdo_en_o),
    .nrz_en_o      (nrz_en_o),
    .fill_active_o (fill_active_o),
    .oe_o          (out_oe_o)
  );

  rdsep_fill_gen #(.FILL_W(FILL_W), .MFM_PAT(MFM_PAT), .FM_PAT(FM_PAT)) u_fill (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (fill_active_o),
    .step_i   (cell_stb_i),
    .mfm_i    (mfm_i),
    .bit_o    (fill_bit_o)
  );

  p_idle_ref_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_gate_i |=> (!lock_data_o && high_gain_o && pf_comp_o && !rdo_en_o && !out_oe_o));
  p_mode_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_OFF && rd_gate_i) |=> $stable(mode_q));
  p_low_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!high_gain_o && rd_gate_i) |=> !high_gain_o);
  p_nrz_needs_rdo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nrz_en_o |-> rdo_en_o && lock_data_o);
  p_fill_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_active_o |-> !rdo_en_o && !nrz_en_o);
  p_lock_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_REF && mode_q && rd_gate_i && pre_cell && cnt == LOCK_M1) |=> lock_data_o && high_gain_o);
endmodule

// File: tb/rdsep_mode_seq_test.sv
module rdsep_mode_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic gate = 0, four = 0, mfm = 0, stb = 0, pulse = 0, pre = 0;
  logic hg, ld, pf, rdo, nrz, fa, fb, oe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rdsep_mode_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .rd_gate_i(gate), .four_state_i(four),
    .mfm_i(mfm), .cell_stb_i(stb), .data_pulse_i(pulse), .pre_seen_i(pre),
    .high_gain_o(hg), .lock_data_o(ld), .pf_comp_o(pf), .rdo_en_o(rdo),
    .nrz_en_o(nrz), .fill_active_o(fa), .fill_bit_o(fb), .out_oe_o(oe)
  );

  // {gate,four,mfm,stb,pulse,pre} -> {hg,ld,pf,rdo,nrz,fa}; two-state run (R1,R3,R4)
  localparam logic [11:0] VEC [14] = '{
    {6'b001000, 6'b101000}, {6'b101000, 6'b101000}, {6'b101101, 6'b101000},
    {6'b101010, 6'b010100}, {6'b101100, 6'b010100}, {6'b101100, 6'b010100},
    {6'b101100, 6'b010100}, {6'b101100, 6'b010100}, {6'b101100, 6'b010100},
    {6'b101100, 6'b010100}, {6'b101100, 6'b010100}, {6'b101100, 6'b010110},
    {6'b101000, 6'b010110}, {6'b001000, 6'b101000}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(logic g, logic s, logic p, logic q);
    gate = g; stb = s; pulse = p; pre = q;
    @(negedge clk);
    stb = 0; pulse = 0;
  endtask

  function automatic logic [7:0] outs();
    return {2'b00, hg, ld, pf, rdo, nrz, fa};
  endfunction

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    if (!done) $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] pat;
    @(negedge clk); @(negedge clk);
    chk("R1 reset", {oe, hg, ld, pf, rdo, nrz, fa, 1'b0}, 8'b01010000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 14; i++) begin
      {gate, four, mfm, stb, pulse, pre} = VEC[i][11:6];
      @(negedge clk);
      stb = 0; pulse = 0;
      chk($sformatf("R3/R4 vector %0d", i), outs(), {2'b00, VEC[i][5:0]});
    end
    chk("R10 oe off after gate low", {7'd0, oe}, 8'd0);

    // four-state MFM: fill, 8 and 16 thresholds, low gain (R5,R6,R8,R9)
    four = 1; mfm = 1; pat = 8'h4E;
    cyc(1, 0, 0, 0);
    chk("R10 oe on in read", {7'd0, oe}, 8'd1);
    chk("R9 fill start", {6'd0, fa, fb}, {6'd0, 1'b1, pat[7]});
    for (int k = 1; k <= 16; k++) begin
      cyc(1, 1, 0, 1);
      if (k < 8)       chk($sformatf("R5 pre %0d ref", k), outs(), 8'b00101001);
      else if (k < 16) chk($sformatf("R5 pre %0d high", k), outs(), 8'b00110001);
      else             chk("R6 pre 16 open", outs(), 8'b00110110);
      if (k < 16) chk($sformatf("R9 fill bit %0d", k), {7'd0, fb}, {7'd0, pat[7 - (k % 8)]});
    end
    cyc(1, 1, 0, 1);
    chk("R6 saturated stays open", outs(), 8'b00110110);
    cyc(1, 1, 0, 0);
    chk("R8 mark drops gain", outs(), 8'b00010110);
    cyc(1, 1, 0, 1);
    cyc(1, 1, 0, 0);
    cyc(1, 0, 1, 1);
    chk("R8 low gain held", outs(), 8'b00010110);
    cyc(0, 0, 0, 0);
    chk("R1 gate low idle", {oe, hg, ld, pf, rdo, nrz, fa, 1'b0}, 8'b01010000);

    // fallback before 16 (R7)
    cyc(1, 0, 0, 0);
    for (int k = 0; k < 10; k++) cyc(1, 1, 0, 1);
    chk("R7 high before drop", outs(), 8'b00110001);
    cyc(1, 1, 0, 0);
    chk("R7 fallback to ref", outs(), 8'b00101001);
    for (int k = 0; k < 7; k++) cyc(1, 1, 0, 1);
    chk("R7 count restarted", outs(), 8'b00101001);
    cyc(1, 1, 0, 1);
    chk("R7 relock after 8", outs(), 8'b00110001);
    cyc(0, 0, 0, 0);

    // FM fill and mode latch (R9,R2)
    mfm = 0; four = 1;
    cyc(1, 0, 0, 0);
    four = 0;
    cyc(1, 0, 1, 0);
    chk("R2 pulse ignored after mode change", outs(), 8'b00101001);
    for (int k = 0; k < 3; k++) begin
      cyc(1, 1, 0, 0);
      chk("R9 FM fill bit", {7'd0, fb}, 8'd1);
    end
    cyc(0, 0, 0, 0);
    four = 0;
    cyc(1, 0, 0, 0);
    chk("R2 two-state latched no fill", outs(), 8'b00101000);
    cyc(1, 1, 0, 1);
    chk("R3 no lock without pulse", outs(), 8'b00101000);
    cyc(0, 0, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule